// File: doc/BRIEF.md
# Predicated Four-Way Interleaving Store Sequencer

This block turns one four-register structure store into a stream of halfword memory writes. On a start pulse it captures the register-number fields, a 64-bit base, a 64-bit index and a per-byte predicate. It checks the encoding and the stack alignment rule. It then walks the elements of four consecutive vector registers. For each element it emits the halfwords of register lanes 0, 1, 2 and 3 at consecutive halfword addresses. The result is a run of four-halfword structures, starting at base plus twice the index.

The four source registers are read through a select output. The surrounding register file returns their contents on a wide data input, which must stay stable while the store runs. Writes leave on a single valid/ready port, at most one halfword per cycle. A one-cycle done pulse follows the last structure, and a one-cycle fault pulse replaces the whole store when it is rejected. Two modes exist. In the normal mode, structures whose predicate bit is clear are skipped and cost no cycles. In the data-independent-timing mode, every structure takes four slots, and the write enable is cleared for inactive structures.

Top module: `ilv_store_seq`

## Requirements
- R1: While reset is held and right after it, `wr_valid`, `done` and `fault` are all 0.
- R2: From the cycle after an accepted start, `rd_sel[5r+4:5r]` for r = 0..3 equals (`zt_field` + r) mod 32, so a first register of 30 selects 30, 31, 0, 1.
- R3: The address of element 0, lane 0 is `base_val` + 2·`index_val`, modulo 2^64.
- R4: The write for element e and lane r has address start + 8e + 2r and data bits [16e+15:16e] of vector r (`rd_data[r*VL +: VL]`). Writes come out in element-major order: element ascending, and lane 0..3 within each element.
- R5: Element e is active when `pred[2e]` is 1, and odd predicate bits are ignored. No write with `wr_en` = 1 is ever issued for an inactive element.
- R6: If `rm_field` is 31, `fault` pulses high on the second cycle after start, with no write offered and no `done`.
- R7: If `rn_field` is 31 and `base_val[3:0]` is nonzero, `fault` pulses as in R6. This applies when at least one element is active. When none is active, it applies only if `sp_chk_idle` is 1. An `rn_field` other than 31 never faults on alignment. R6 takes precedence over R7.
- R8: With `dit_en` = 1 and `wr_ready` held high, exactly 4·(VL/16) slots are offered with `wr_valid` = 1 and `wr_en` = `pred[2e]`. `done` follows 4·(VL/16)+2 cycles after start, for every predicate value.
- R9: With `dit_en` = 0, only active structures are offered, each with `wr_en` = 1. With no active element, `done` pulses on the second cycle after start and no write is offered.
- R10: While `wr_valid` is 1 and `wr_ready` is 0, the same write stays offered with an unchanged address on the next cycle.
- R11: `done` is a single-cycle pulse on the cycle after the final write is accepted.
- R12: A start pulse while a store is in progress is ignored, and the write stream of the running store is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a store (sampled when idle) |
| zt_field | input | 5 | First source vector register number |
| rn_field | input | 5 | Base register field, 31 selects the stack pointer |
| rm_field | input | 5 | Index register field, 31 is rejected |
| base_val | input | 64 | Base address value |
| index_val | input | 64 | Index value, in halfwords |
| pred | input | VL/8 | Predicate, one bit per byte |
| dit_en | input | 1 | Data-independent timing mode |
| sp_chk_idle | input | 1 | Apply stack alignment check even with no active element |
| rd_sel | output | 20 | Four 5-bit register selects, lane 0 in the low bits |
| rd_data | input | 4*VL | Selected registers, lane 0 in the low bits |
| wr_valid | output | 1 | Write slot offered |
| wr_ready | input | 1 | Memory accepts the slot |
| wr_en | output | 1 | Slot actually writes |
| wr_addr | output | 64 | Halfword address |
| wr_data | output | 16 | Halfword data |
| done | output | 1 | Store completed, one-cycle pulse |
| fault | output | 1 | Store rejected, one-cycle pulse |

## Verification
Two situations are the hardest to reach from the ports. One is a skip across a gap of inactive elements in the normal mode. The other is the same walk under back-pressure, where a stalled slot must hold while the element pointer would otherwise jump. The bench drives every pattern of the eight even predicate bits in both timing modes, so every gap shape between active elements occurs. It stalls `wr_ready` on a fixed rhythm in a subset of those runs, and fires a second start mid-run in another subset. The alignment rule is reached by setting the base field to 31 with misaligned bases, both with and without active elements.

// File: rtl/ilv_store_pkg.sv
// Package: shared types and constants for the interleaving store sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package ilv_store_pkg;

    // Sequencer phase.
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CHECK = 2'd1,
        S_RUN   = 2'd2
    } seq_state_t;

    // Register field value with special meaning (stack pointer / rejected).
    localparam logic [4:0] REG_SPECIAL = 5'd31;

    // Number of vector registers interleaved per structure.
    localparam int NLANE = 4;

endpackage

// File: rtl/ilv_st_decode.sv
// Module: encoding and stack alignment check.
// Decides whether a captured store must be rejected. A rejected index field
// takes precedence over the alignment rule. The alignment rule needs a
// 16-byte aligned stack pointer. It is skipped when no element is active,
// unless the idle check is configured.
// Assumes: inputs are stable captured values; purely combinational.
module ilv_st_decode
    import ilv_store_pkg::*;
(
    input  logic [4:0] rm_fld,
    input  logic [4:0] rn_fld,
    input  logic [3:0] base_lo,
    input  logic       any_act,
    input  logic       chk_idle,
    output logic       bad_enc,
    output logic       bad_align,
    output logic       reject
);

    logic sp_base;
    logic chk_apply;

    // Classify the fields and combine the two rejection causes.
    always_comb begin
        sp_base   = (rn_fld == REG_SPECIAL);
        chk_apply = any_act | chk_idle;
        bad_enc   = (rm_fld == REG_SPECIAL);
        bad_align = sp_base && chk_apply && (base_lo != 4'd0);
        reject    = bad_enc | bad_align;
    end

endmodule

// File: rtl/ilv_st_scan.sv
// Module: active element scanner.
// Finds the lowest active element overall, and the lowest active element
// strictly above a given element. Used to skip inactive structures in zero
// cycles.
// Assumes: NELEM is a power of two; combinational priority encoders.
module ilv_st_scan #(
    parameter  int NELEM = 32,
    localparam int EW    = $clog2(NELEM)
) (
    input  logic [NELEM-1:0] act,
    input  logic [EW-1:0]    cur,
    output logic             first_found,
    output logic [EW-1:0]    first_idx,
    output logic             next_found,
    output logic [EW-1:0]    next_idx
);

    logic [NELEM-1:0] above;

    // Mask of element positions strictly above the current one.
    generate
        for (genvar g = 0; g < NELEM; g++) begin : g_above
            assign above[g] = (g > int'(cur));
        end
    endgenerate

    // Lowest set bit of the full active vector.
    always_comb begin
        first_found = 1'b0;
        first_idx   = '0;
        for (int i = NELEM - 1; i >= 0; i--) begin
            if (act[i]) begin
                first_found = 1'b1;
                first_idx   = EW'(i);
            end
        end
    end

    // Lowest set bit of the active vector above the current element.
    always_comb begin
        next_found = 1'b0;
        next_idx   = '0;
        for (int i = NELEM - 1; i >= 0; i--) begin
            if (act[i] && above[i]) begin
                next_found = 1'b1;
                next_idx   = EW'(i);
            end
        end
    end

endmodule

// File: rtl/ilv_st_lane.sv
// Module: halfword selector.
// Picks the halfword of one element from one of the four selected vector
// registers.
// Assumes: rd_data holds lane 0 in its low VL bits; combinational.
module ilv_st_lane
    import ilv_store_pkg::*;
#(
    parameter  int VL    = 512,
    localparam int NELEM = VL / 16,
    localparam int EW    = $clog2(NELEM)
) (
    input  logic [NLANE*VL-1:0] rd_data,
    input  logic [EW-1:0]       elem,
    input  logic [1:0]          lane,
    output logic [15:0]         hw
);

    logic [VL-1:0] vec [NLANE];
    logic [VL-1:0] vsel;

    // Split the flat register bus into one vector per lane.
    generate
        for (genvar g = 0; g < NLANE; g++) begin : g_vec
            assign vec[g] = rd_data[g*VL +: VL];
        end
    endgenerate

    // Lane select, then element select.
    always_comb begin
        vsel = vec[lane];
        hw   = vsel[{elem, 4'b0000} +: 16];
    end

endmodule

// File: rtl/ilv_store_seq.sv
// Module: predicated four-way interleaving store sequencer (top).
// Captures a store request, checks it, and then issues halfword writes in
// element-major order over a valid/ready port. Normal mode skips inactive
// structures. The data-independent-timing mode spends four slots per
// element and clears wr_en for inactive structures.
// Assumes: rd_data is stable while a store runs. For fixed timing, wr_ready
// is held high in the data-independent-timing mode.
module ilv_store_seq
    import ilv_store_pkg::*;
#(
    parameter  int VL    = 512,
    localparam int NELEM = VL / 16,
    localparam int PW    = VL / 8,
    localparam int EW    = $clog2(NELEM)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [4:0]          zt_field,
    input  logic [4:0]          rn_field,
    input  logic [4:0]          rm_field,
    input  logic [63:0]         base_val,
    input  logic [63:0]         index_val,
    input  logic [PW-1:0]       pred,
    input  logic                dit_en,
    input  logic                sp_chk_idle,
    output logic [19:0]         rd_sel,
    input  logic [NLANE*VL-1:0] rd_data,
    output logic                wr_valid,
    input  logic                wr_ready,
    output logic                wr_en,
    output logic [63:0]         wr_addr,
    output logic [15:0]         wr_data,
    output logic                done,
    output logic                fault
);

    seq_state_t       state_q;
    logic [4:0]       t_q, rn_q, rm_q;
    logic [3:0]       base_lo_q;
    logic [63:0]      sa_q;
    logic [NELEM-1:0] act_q;
    logic             dit_q, chk_q;
    logic [EW-1:0]    elem_q;
    logic [1:0]       lane_q;
    logic             done_q, fault_q;

    logic [NELEM-1:0] act_in;
    logic [NELEM-1:0] odd_in;
    logic             unused_bits;
    logic             first_found, next_found;
    logic [EW-1:0]    first_idx, next_idx;
    logic             bad_enc, bad_align, reject;
    logic             accept, last_elem;

    // Element e is governed by the even predicate bit 2e; odd bits are unused.
    generate
        for (genvar g = 0; g < NELEM; g++) begin : g_pred
            assign act_in[g] = pred[2*g];
            assign odd_in[g] = pred[2*g+1];
        end
    endgenerate

    assign unused_bits = ^{odd_in, index_val[63]};

    // Lane r reads register (t + r) mod 32; 5-bit addition wraps naturally.
    generate
        for (genvar g = 0; g < NLANE; g++) begin : g_sel
            assign rd_sel[g*5 +: 5] = t_q + 5'(g);
        end
    endgenerate

    ilv_st_decode u_decode (
        .rm_fld    (rm_q),
        .rn_fld    (rn_q),
        .base_lo   (base_lo_q),
        .any_act   (first_found),
        .chk_idle  (chk_q),
        .bad_enc   (bad_enc),
        .bad_align (bad_align),
        .reject    (reject)
    );

    ilv_st_scan #(.NELEM(NELEM)) u_scan (
        .act         (act_q),
        .cur         (elem_q),
        .first_found (first_found),
        .first_idx   (first_idx),
        .next_found  (next_found),
        .next_idx    (next_idx)
    );

    ilv_st_lane #(.VL(VL)) u_lane (
        .rd_data (rd_data),
        .elem    (elem_q),
        .lane    (lane_q),
        .hw      (wr_data)
    );

    // Handshake and end-of-walk decisions for the current slot.
    always_comb begin
        accept    = (state_q == S_RUN) && wr_ready;
        last_elem = dit_q ? (elem_q == EW'(NELEM - 1)) : !next_found;
    end

    // Write port: offset 8e + 2r is a plain bit concatenation onto the start address.
    always_comb begin
        wr_valid = (state_q == S_RUN);
        wr_en    = wr_valid && (dit_q ? act_q[elem_q] : 1'b1);
        wr_addr  = sa_q + {{(61-EW){1'b0}}, elem_q, lane_q, 1'b0};
        done     = done_q;
        fault    = fault_q;
    end

    // Capture the request when idle; it is ignored at any other time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q       <= '0;
            rn_q      <= '0;
            rm_q      <= '0;
            base_lo_q <= '0;
            sa_q      <= '0;
            act_q     <= '0;
            dit_q     <= 1'b0;
            chk_q     <= 1'b0;
        end else if (state_q == S_IDLE && start) begin
            t_q       <= zt_field;
            rn_q      <= rn_field;
            rm_q      <= rm_field;
            base_lo_q <= base_val[3:0];
            sa_q      <= base_val + {index_val[62:0], 1'b0};
            act_q     <= act_in;
            dit_q     <= dit_en;
            chk_q     <= sp_chk_idle;
        end
    end

    // Sequencer: check, then walk elements and lanes, and pulse done or fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            elem_q  <= '0;
            lane_q  <= '0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start) state_q <= S_CHECK;
                end
                S_CHECK: begin
                    lane_q <= '0;
                    if (reject) begin
                        fault_q <= 1'b1;
                        state_q <= S_IDLE;
                    end else if (!dit_q && !first_found) begin
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                    end else begin
                        elem_q  <= dit_q ? '0 : first_idx;
                        state_q <= S_RUN;
                    end
                end
                S_RUN: begin
                    if (accept) begin
                        if (lane_q != 2'd3) begin
                            lane_q <= lane_q + 2'd1;
                        end else if (last_elem) begin
                            lane_q  <= '0;
                            done_q  <= 1'b1;
                            state_q <= S_IDLE;
                        end else begin
                            lane_q <= '0;
                            elem_q <= dit_q ? elem_q + EW'(1) : next_idx;
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !wr_valid && !done); // R6

    AST_EN_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_en) |-> act_q[elem_q]); // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr)); // R10

    AST_LANE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && lane_q != 2'd3) |=> wr_valid && (wr_addr == $past(wr_addr) + 64'd2)); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !(wr_ready && lane_q == 2'd3 && last_elem)) |=> wr_valid); // R12

endmodule

// File: tb/ilv_store_seq_tb.sv
`timescale 1ns/1ps
// Bench: sweeps every even-bit predicate pattern in both timing modes on a
// VL=128 build, plus directed fault and wrap cases.
module ilv_store_seq_tb;

    localparam int VL    = 128;
    localparam int NELEM = VL / 16;
    localparam int PW    = VL / 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [4:0]      zt_field = '0, rn_field = '0, rm_field = '0;
    logic [63:0]     base_val = '0, index_val = '0;
    logic [PW-1:0]   pred = '0;
    logic            dit_en = 1'b0, sp_chk_idle = 1'b0;
    logic [19:0]     rd_sel;
    logic [4*VL-1:0] rd_data;
    logic            wr_valid, wr_ready = 1'b1, wr_en;
    logic [63:0]     wr_addr;
    logic [15:0]     wr_data;
    logic            done, fault;

    logic [VL-1:0]   vregs [0:31];
    int              n_chk = 0, n_bad = 0;
    bit              finished = 0;

    always #5 clk = ~clk;

    ilv_store_seq #(.VL(VL)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .zt_field(zt_field),
        .rn_field(rn_field), .rm_field(rm_field), .base_val(base_val),
        .index_val(index_val), .pred(pred), .dit_en(dit_en),
        .sp_chk_idle(sp_chk_idle), .rd_sel(rd_sel), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .fault(fault)
    );

    // Register file model answering the four selects.
    generate
        for (genvar g = 0; g < 4; g++) begin : g_rf
            assign rd_data[g*VL +: VL] = vregs[rd_sel[g*5 +: 5]];
        end
    endgenerate

    task automatic check(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic fill_regs(input int seed);
        for (int r = 0; r < 32; r++)
            for (int e = 0; e < NELEM; e++)
                vregs[r][16*e +: 16] = {r[4:0], e[4:0], 6'(seed + r * 3 + e)};
    endtask

    // One store: drive, collect, and compare against the requirement model.
    task automatic run_case(input logic [4:0] t, input logic [4:0] rn, input logic [4:0] rm,
                            input logic [63:0] b, input logic [63:0] ix,
                            input logic [PW-1:0] pr, input bit d, input bit ck,
                            input bit stl, input bit again);
        logic [63:0] ea [0:39];
        logic [15:0] ed [0:39];
        logic        ee [0:39];
        logic [63:0] sa, hold_a;
        int nexp = 0, nb = 0, lat = 0;
        bit anyact = 0, exp_fault, seen_done = 0, seen_fault = 0, hold = 0;
        for (int e = 0; e < NELEM; e++) anyact |= pr[2*e];
        // R6 precedence over R7; R7 idle rule.
        exp_fault = (rm == 5'd31) || (rn == 5'd31 && b[3:0] != 4'd0 && (anyact || ck));
        sa = b + ix * 64'd2;  // R3
        if (!exp_fault)
            for (int e = 0; e < NELEM; e++)
                if (d || pr[2*e])
                    for (int r = 0; r < 4; r++) begin
                        ea[nexp] = sa + 64'(8 * e + 2 * r);
                        ed[nexp] = vregs[5'(t + 5'(r))][16*e +: 16];
                        ee[nexp] = pr[2*e];
                        nexp++;
                    end
        @(negedge clk);
        zt_field = t; rn_field = rn; rm_field = rm; base_val = b; index_val = ix;
        pred = pr; dit_en = d; sp_chk_idle = ck; wr_ready = 1'b1; start = 1'b1;
        for (int i = 1; i < 300; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (again && i == 4) begin
                start = 1'b1; base_val = ~b; zt_field = t + 5'd7; pred = ~pr; dit_en = ~d;
            end
            wr_ready = stl ? (i % 3 != 0) : 1'b1;
            #2;
            if (i == 1)
                for (int r = 0; r < 4; r++)
                    check(rd_sel[r*5 +: 5] == 5'(t + 5'(r)),
                          $sformatf("R2 lane %0d sel act=%0d exp=%0d", r, rd_sel[r*5 +: 5], 5'(t + 5'(r))));
            if (hold) begin
                check(wr_valid && wr_addr == hold_a,
                      $sformatf("R10 stall hold act=%0d/%h exp=1/%h", wr_valid, wr_addr, hold_a));
                hold = 0;
            end
            if (wr_valid && !wr_ready) begin hold = 1; hold_a = wr_addr; end
            if (wr_valid && wr_ready) begin
                if (nb < nexp)
                    check(wr_addr == ea[nb] && wr_data == ed[nb] && wr_en == ee[nb],
                          $sformatf("R4/R5/R8/R9 beat %0d act=%h/%h/%0d exp=%h/%h/%0d",
                                    nb, wr_addr, wr_data, wr_en, ea[nb], ed[nb], ee[nb]));
                nb++;
            end
            if (done) begin seen_done = 1; lat = i; break; end
            if (fault) begin seen_fault = 1; lat = i; break; end
        end
        check(nb == nexp, $sformatf("R8/R9 beat count act=%0d exp=%0d", nb, nexp));
        check(seen_fault == exp_fault && seen_done == !exp_fault,
              $sformatf("R6/R7 outcome act=done%0d fault%0d exp=done%0d fault%0d",
                        seen_done, seen_fault, !exp_fault, exp_fault));
        if (!stl)
            check(lat == nexp + 2, $sformatf("R8/R9/R11 latency act=%0d exp=%0d", lat, nexp + 2));
        @(negedge clk); #2;
        check(!done && !fault && !wr_valid,
              $sformatf("R11 single pulse act=%0d%0d%0d exp=000", done, fault, wr_valid));
        pred = pr; dit_en = d;
    endtask

    initial begin
        fill_regs(5);
        repeat (3) @(negedge clk);
        #2;
        check(!wr_valid && !done && !fault, "R1 in reset act=active exp=idle");
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #2;
        check(!wr_valid && !done && !fault, "R1 after reset act=active exp=idle");

        // Sweep all even-bit patterns in both modes.
        for (int d = 0; d < 2; d++) begin
            for (int p = 0; p < 256; p++) begin
                logic [PW-1:0] pr;
                logic [7:0] pb = 8'(p);
                for (int e = 0; e < NELEM; e++) begin
                    pr[2*e]   = pb[e];
                    pr[2*e+1] = ~pb[e] ^ pb[(e + 1) % 8];  // R5 odd bits ignored
                end
                if (p % 64 == 0) fill_regs(p + d);
                run_case(5'(p), 5'(p % 31), 5'(p % 30),
                         64'hFFFF_FFFF_FFFF_FF00 + 64'(p * 24),
                         64'(p) * 64'h0123_4567_89AB_CDEF, pr, d[0], 1'b0,
                         (p % 5 == 0), (p % 7 == 3));  // R10 stalls, R12 restarts
            end
        end

        // R2 wrap of register numbers, R3 wrap of address.
        run_case(5'd30, 5'd3, 5'd4, 64'hFFFF_FFFF_FFFF_FFF0, 64'd8, 16'h5555, 1'b0, 1'b0, 1'b0, 1'b0);
        // R6 rejected index field, in both modes and with an SP base too.
        run_case(5'd1, 5'd2, 5'd31, 64'h1000, 64'd0, 16'h5555, 1'b0, 1'b0, 1'b0, 1'b0);
        run_case(5'd1, 5'd31, 5'd31, 64'h1003, 64'd0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0);
        // R7 alignment rule.
        run_case(5'd2, 5'd31, 5'd0, 64'h1008, 64'd1, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0);
        run_case(5'd2, 5'd31, 5'd0, 64'h1010, 64'd1, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0);
        run_case(5'd2, 5'd31, 5'd0, 64'h1001, 64'd1, 16'hAAAA, 1'b0, 1'b0, 1'b0, 1'b0);
        run_case(5'd2, 5'd31, 5'd0, 64'h1001, 64'd1, 16'hAAAA, 1'b0, 1'b1, 1'b0, 1'b0);
        run_case(5'd2, 5'd31, 5'd0, 64'h1001, 64'd1, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0);
        run_case(5'd2, 5'd30, 5'd0, 64'h1001, 64'd1, 16'h0040, 1'b0, 1'b1, 1'b0, 1'b0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1_500_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule